// File: doc/BRIEF.md
# Multimaster Bus Arbitration Agent

This block sits beside one local processor and decides when that processor may drive a system bus that several masters share. The local side gives it a request and a lock input. The block returns an enable that keeps the local bus drivers off the shared bus until the bus has been won. A processor whose bus has not been won issues no command, gets no acknowledge and waits.

On the shared side, the agent raises an active-low request and watches an active-low priority input. It takes part in a shared BUSY line: it reads the wired value, and it pulls the line low when it owns the bus. It also drives an active-low priority output, so that agents can be daisy chained: priority passes to the next lower agent only when this agent has priority and does not need the bus.

Every input is brought through a two-flop synchronizer clocked by the bus clock. Ownership is taken only when priority is present, the BUSY line is free, and a request is pending. The bus is held for the whole transfer and for as long as the lock input is active. When the agent has no work and still holds priority, it parks on the bus.

Top module: `mbus_arb_agent`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the next outputs are `bus_en_o`=0, `busy_drive_o`=0, `req_n_o`=1 and `prio_out_n_o`=1.
- R2: Each asynchronous input (`loc_req_i`, `lock_i`, `prio_in_n_i`, `busy_n_i`) passes through two bus-clock flops. A change applied between edges shows at the outputs on the third rising edge that follows, and not earlier.
- R3: `bus_en_o` and `busy_drive_o` are 1 only while the agent owns the bus. While waiting, `req_n_o`=0 and `prio_out_n_o`=1. While owning, `prio_out_n_o`=1, and `req_n_o`=0 only if the local request or the lock is active.
- R4: Ownership is taken only when the synchronized request is 1, the synchronized priority is asserted (`prio_in_n_i`=0) and the synchronized BUSY line is free (`busy_n_i`=1). While another master holds BUSY low, the agent keeps waiting.
- R5: Without priority (`prio_in_n_i`=1), a requesting agent never takes the bus. It keeps `bus_en_o`=0 and `req_n_o`=0.
- R6: While the local request stays 1, an owner keeps the bus even after it loses priority.
- R7: An owner releases the bus (`bus_en_o`=0, `busy_drive_o`=0) once its request is 0, its lock is 0 and it has no priority. If priority is still present, it stays parked on the bus.
- R8: While `lock_i`=1, an owner keeps the bus even with its request at 0 and no priority, and it holds `req_n_o`=0.
- R9: An agent that is idle drives `prio_out_n_o`=0 when it has priority, and `prio_out_n_o`=1 when it does not.
- R10: If the request is withdrawn before the bus is won, the agent goes back to idle and `req_n_o` returns to 1.
- R11: An agent whose priority input is held low acquires the bus whenever it requests and the BUSY line is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_req_i | input | 1 | Local request for the shared bus, asynchronous |
| lock_i | input | 1 | Hold the bus for an atomic sequence, asynchronous |
| prio_in_n_i | input | 1 | Priority granted to this agent, active low |
| busy_n_i | input | 1 | Wired BUSY line as sensed, low while any master owns the bus |
| req_n_o | output | 1 | Bus request to the resolver, active low |
| prio_out_n_o | output | 1 | Priority passed to the next lower agent, active low |
| busy_drive_o | output | 1 | 1 pulls the shared BUSY line low (open-drain enable) |
| bus_en_o | output | 1 | Enable for the local bus controller, transceivers and latches |

## Verification
The hardest situation to reach is the owner that loses priority in the middle of an atomic sequence. In that case the lock input alone must keep the bus, with the request already dropped and priority gone. The bench gets there by acquiring with the lock raised, then removing priority and the request together, and watching that the bus is still held after the synchronizer delay. It then drops the lock and expects the release on exactly the third edge. A second awkward case is another master holding BUSY while this agent has priority. The bench models the wired line as the AND of both pull-downs, so that the agent's own drive and the foreign drive combine as they would on the board.

// File: rtl/mbarb_pkg.sv
`timescale 1ns/1ps
package mbarb_pkg;

    // number of asynchronous inputs carried through the synchronizer
    localparam int SYNC_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2
    } agent_st_e;

    // synchronized inputs, all active high
    typedef struct packed {
        logic req;
        logic lock;
        logic prio;
        logic busy;
    } sync_vec_t;

    // every register of the control block
    typedef struct packed {
        agent_st_e st;
        logic      bus_en;
        logic      busy_drv;
        logic      req_n;
        logic      prio_out_n;
    } ctrl_reg_t;

endpackage

// File: rtl/mbarb_sync.sv
`timescale 1ns/1ps
module mbarb_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_comb stage_d[k] = din;
            end else begin : g_next
                always_comb stage_d[k] = stage_q[k-1];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[k] <= RST_VAL;
                else        stage_q[k] <= stage_d[k];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

    // R2: the first flop captures the raw input one edge later
    assert_first_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage_q[0] == $past(din)));

endmodule

// File: rtl/mbarb_ctrl.sv
`timescale 1ns/1ps
module mbarb_ctrl
    import mbarb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sync_vec_t s,
    output logic      bus_en_o,
    output logic      busy_drv_o,
    output logic      req_n_o,
    output logic      prio_out_n_o
);

    localparam ctrl_reg_t RST_REG = '{st: ST_IDLE, bus_en: 1'b0, busy_drv: 1'b0,
                                      req_n: 1'b1, prio_out_n: 1'b1};

    ctrl_reg_t r_d, r_q;
    logic      may_take;
    logic      may_drop;
    logic      own_q;

    always_comb begin
        r_d      = r_q;
        may_take = s.req && s.prio && !s.busy;
        may_drop = !s.req && !s.lock && !s.prio;

        unique case (r_q.st)
            ST_IDLE, ST_WAIT: begin
                if (may_take)   r_d.st = ST_OWN;
                else if (s.req) r_d.st = ST_WAIT;
                else            r_d.st = ST_IDLE;
            end
            ST_OWN: begin
                if (may_drop) r_d.st = ST_IDLE;
                else          r_d.st = ST_OWN;
            end
            default: r_d.st = ST_IDLE;
        endcase

        r_d.bus_en     = (r_d.st == ST_OWN);
        r_d.busy_drv   = (r_d.st == ST_OWN);
        r_d.req_n      = !((r_d.st == ST_WAIT) ||
                           ((r_d.st == ST_OWN) && (s.req || s.lock)));
        r_d.prio_out_n = (r_d.st != ST_IDLE) || !s.prio;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RST_REG;
        else        r_q <= r_d;
    end

    assign own_q        = (r_q.st == ST_OWN);
    assign bus_en_o     = r_q.bus_en;
    assign busy_drv_o   = r_q.busy_drv;
    assign req_n_o      = r_q.req_n;
    assign prio_out_n_o = r_q.prio_out_n;

    // R4: the bus is taken only with priority, request and a free line
    assert_take_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_q) |-> ($past(s.prio) && $past(s.req) && !$past(s.busy)));

    // R5: without priority, an agent that does not own stays off the bus
    assert_no_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_q && !s.prio) |=> !own_q);

    // R6: an active transfer keeps ownership
    assert_hold_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q && s.req) |=> own_q);

    // R7: release only when idle, unlocked and without priority
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_q) |-> (!$past(s.req) && !$past(s.lock) && !$past(s.prio)));

    // R8: the lock keeps ownership
    assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q && s.lock) |=> own_q);

endmodule

// File: rtl/mbus_arb_agent.sv
`timescale 1ns/1ps
module mbus_arb_agent
    import mbarb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loc_req_i,
    input  logic lock_i,
    input  logic prio_in_n_i,
    input  logic busy_n_i,
    output logic req_n_o,
    output logic prio_out_n_o,
    output logic busy_drive_o,
    output logic bus_en_o
);

    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] sync_bits;
    sync_vec_t         sync_s;

    // convert everything to active high before synchronizing
    assign raw_vec = {loc_req_i, lock_i, ~prio_in_n_i, ~busy_n_i};

    mbarb_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_vec),
        .dout  (sync_bits)
    );

    assign sync_s = sync_vec_t'(sync_bits);

    mbarb_ctrl ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .s            (sync_s),
        .bus_en_o     (bus_en_o),
        .busy_drv_o   (busy_drive_o),
        .req_n_o      (req_n_o),
        .prio_out_n_o (prio_out_n_o)
    );

    // R1: reset returns every output to its inactive level
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!bus_en_o && !busy_drive_o && req_n_o && prio_out_n_o));

    // R3: an owner never passes priority on
    assert_owner_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_o |-> prio_out_n_o);

    // R3: enable and BUSY drive move together
    assert_en_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_o == busy_drive_o);

endmodule

// File: tb/mbus_arb_agent_tb_top.sv
`timescale 1ns/1ps
module mbus_arb_agent_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic loc_req, lock, prio_in_n, other_busy;
    logic busy_n_line;
    logic req_n, prio_out_n, busy_drive, bus_en;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    always #5 clk = ~clk;

    // wired BUSY: low when either master pulls it
    assign busy_n_line = ~(busy_drive | other_busy);

    mbus_arb_agent dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .loc_req_i    (loc_req),
        .lock_i       (lock),
        .prio_in_n_i  (prio_in_n),
        .busy_n_i     (busy_n_line),
        .req_n_o      (req_n),
        .prio_out_n_o (prio_out_n),
        .busy_drive_o (busy_drive),
        .bus_en_o     (bus_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 bus_en", bus_en, 1'b0);
        chk("R1 busy_drive", busy_drive, 1'b0);
        chk("R1 req_n", req_n, 1'b1);
        chk("R1 prio_out_n", prio_out_n, 1'b1);
    endtask

    task automatic t_acquire_park;
        prio_in_n = 1'b0;
        wait_edges(3);
        chk("R9 idle with priority passes it", prio_out_n, 1'b0);
        loc_req = 1'b1;
        wait_edges(2);
        chk("R2 no grant before third edge", bus_en, 1'b0);
        wait_edges(1);
        chk("R2 grant on third edge", bus_en, 1'b1);
        chk("R11 busy driven", busy_drive, 1'b1);
        chk("R3 owner requests", req_n, 1'b0);
        chk("R3 owner blocks chain", prio_out_n, 1'b1);
        loc_req = 1'b0;
        wait_edges(6);
        chk("R7 parked with priority", bus_en, 1'b1);
        chk("R3 parked owner drops request", req_n, 1'b1);
        prio_in_n = 1'b1;
        wait_edges(3);
        chk("R7 release after priority loss", bus_en, 1'b0);
        chk("R7 busy released", busy_drive, 1'b0);
        chk("R9 no priority blocks chain", prio_out_n, 1'b1);
    endtask

    task automatic t_busy_wait;
        other_busy = 1'b1;
        prio_in_n  = 1'b0;
        wait_edges(3);
        loc_req = 1'b1;
        wait_edges(6);
        chk("R4 waits while line busy", bus_en, 1'b0);
        chk("R3 waiting requests", req_n, 1'b0);
        chk("R3 waiting blocks chain", prio_out_n, 1'b1);
        other_busy = 1'b0;
        wait_edges(2);
        chk("R2 line free not yet seen", bus_en, 1'b0);
        wait_edges(1);
        chk("R4 takes bus once free", bus_en, 1'b1);
        loc_req   = 1'b0;
        prio_in_n = 1'b1;
        wait_edges(4);
        chk("R7 release after busy test", bus_en, 1'b0);
    endtask

    task automatic t_no_prio;
        prio_in_n = 1'b1;
        loc_req   = 1'b1;
        wait_edges(8);
        chk("R5 no priority no grant", bus_en, 1'b0);
        chk("R5 request held", req_n, 1'b0);
        loc_req = 1'b0;
        wait_edges(3);
        chk("R10 withdrawn request", req_n, 1'b1);
        chk("R10 still off bus", bus_en, 1'b0);
    endtask

    task automatic t_hold_transfer;
        prio_in_n = 1'b0;
        loc_req   = 1'b1;
        wait_edges(4);
        chk("R11 acquire for transfer", bus_en, 1'b1);
        prio_in_n = 1'b1;
        wait_edges(8);
        chk("R6 hold during transfer", bus_en, 1'b1);
        chk("R6 busy held", busy_drive, 1'b1);
        loc_req = 1'b0;
        wait_edges(2);
        chk("R6 still held before sync", bus_en, 1'b1);
        wait_edges(1);
        chk("R7 release at transfer end", bus_en, 1'b0);
    endtask

    task automatic t_lock;
        prio_in_n = 1'b0;
        loc_req   = 1'b1;
        lock      = 1'b1;
        wait_edges(4);
        chk("R8 acquire with lock", bus_en, 1'b1);
        prio_in_n = 1'b1;
        loc_req   = 1'b0;
        wait_edges(8);
        chk("R8 lock keeps bus", bus_en, 1'b1);
        chk("R8 lock keeps request", req_n, 1'b0);
        lock = 1'b0;
        wait_edges(3);
        chk("R8 release after unlock", bus_en, 1'b0);
        chk("R8 request dropped", req_n, 1'b1);
    endtask

    task automatic t_chain;
        prio_in_n = 1'b0;
        wait_edges(2);
        chk("R2 chain not yet passed", prio_out_n, 1'b1);
        wait_edges(1);
        chk("R9 chain passed", prio_out_n, 1'b0);
        prio_in_n = 1'b1;
        wait_edges(3);
        chk("R9 chain withdrawn", prio_out_n, 1'b1);
    endtask

    initial begin
        rst_n      = 1'b0;
        loc_req    = 1'b0;
        lock       = 1'b0;
        prio_in_n  = 1'b1;
        other_busy = 1'b0;
        wait_edges(3);
        t_reset();
        rst_n = 1'b1;
        wait_edges(2);
        t_acquire_park();
        t_busy_wait();
        t_no_prio();
        t_hold_transfer();
        t_lock();
        t_chain();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule